// File: doc/BRIEF.md
# Oversampling Accumulator Decimation Filter

This block adds a selectable run of consecutive 12-bit converter samples into a 20-bit running sum. It emits one result per decimation window, so it acts as a boxcar (sinc) decimation filter. A window holds 4^N samples, with N from 0 to 4. Shifting the finished sum right by N bits gives a result with N more bits of resolution than a single sample. With the longest window of 256 samples, the 12-bit input grows to a 16-bit result.

A converter feeds the block with a valid strobe, a 12-bit code and a tag that marks samples taken from the temperature sensor. Tagged samples never enter the sum. A synchronous clear restarts the current window, and an enable gates acceptance of new samples. A unipolar/bipolar select sets how codes are read: unipolar codes are straight binary, and bipolar codes are two's complement. When the final sample of a window is taken, the block registers the raw sum and the extended result and raises a one-cycle done strobe.

Top module: `osf_top`

## Requirements
- R1: A sample is accepted only in a cycle where smp_vld_i=1, en_i=1, src_temp_i=0 and clr_i=0. In unipolar mode (bipolar_i=0), the 12-bit code is zero-extended and added to the running sum.
- R2: ratio_sel_i=N for N in 0..4 sets the window to 4^N accepted samples (1, 4, 16, 64, 256). Any value above 4 acts as 4.
- R3: The clock edge that takes the last sample of a window drives done_o high for one cycle. On that same edge, sum_o gets the 20-bit window total, and the next window starts from a zero sum. No other event asserts done_o.
- R4: ext_o is bits [15:0] of the captured total shifted right by N.
- R5: A sample tagged src_temp_i=1 changes neither the sum nor the sample count.
- R6: A sample presented while en_i=0 changes neither the sum nor the sample count.
- R7: clr_i=1 zeroes the sum and the sample count on the next edge. It produces no done_o, and sum_o and ext_o keep their values.
- R8: When bipolar_i=1, each code is read as 12-bit two's complement and sign-extended to 20 bits. ext_o then uses an arithmetic shift.
- R9: After reset, sum_o=0, ext_o=0 and done_o=0.
- R10: Full-scale cases wrap nothing. 256 unipolar samples of 4095 give sum_o=1048320 and ext_o=65520. 256 bipolar samples of -2048 give sum_o=20'h80000 and ext_o=16'h8000.
- R11: With N=0, every accepted sample is a complete window, so done_o may stay high on consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Accept samples when high |
| clr_i | input | 1 | Synchronous restart of the current window |
| bipolar_i | input | 1 | 1: two's complement codes, 0: straight binary |
| ratio_sel_i | input | 3 | Extra-bit count N; window is 4^N samples |
| smp_vld_i | input | 1 | Sample strobe |
| smp_i | input | 12 | Converter code |
| src_temp_i | input | 1 | Sample comes from the temperature sensor |
| sum_o | output | 20 | Captured window total |
| ext_o | output | 16 | Total shifted right by N |
| done_o | output | 1 | One-cycle strobe when a window completes |

## Verification
The bench builds the block with its default parameters: 12-bit samples, a 20-bit accumulator and a largest extra-bit count of 4. With these values, every ratio from 1 to 256 and the clamped selection above 4 can be reached, along with both 256-sample full-scale corners in each coding. That covers the exact 20-bit ceiling and the most negative sum. Windows mix in temperature-tagged and disabled samples, a clear lands in the middle of a window, and N=0 runs back-to-back done strobes.

// File: rtl/osf_pkg.sv
package osf_pkg;
  // clamp a ratio select to the largest supported extra-bit count
  function automatic int clamp_sel(input int sel, input int max_n);
    return (sel > max_n) ? max_n : sel;
  endfunction
endpackage

// File: rtl/osf_ratio_dec.sv
module osf_ratio_dec #(
  parameter int SEL_W = 3,
  parameter int MAX_N = 4,
  parameter int CNT_W = 2 * MAX_N,
  parameter int SH_W  = $clog2(MAX_N + 1)
) (
  input  logic [SEL_W-1:0] sel_i,
  output logic [CNT_W-1:0] last_o,
  output logic [SH_W-1:0]  shift_o
);
  logic [CNT_W-1:0] last_lut [MAX_N+1];

  for (genvar g = 0; g <= MAX_N; g++) begin : g_lut
    assign last_lut[g] = CNT_W'((64'd1 << (2 * g)) - 64'd1);
  end

  always_comb begin
    int n;
    n       = osf_pkg::clamp_sel(int'(sel_i), MAX_N);
    last_o  = last_lut[n];
    shift_o = SH_W'(n);
  end
endmodule

// File: rtl/osf_counter.sv
module osf_counter #(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             take_i,
  input  logic [CNT_W-1:0] last_i,
  output logic             wrap_o
);
  logic [CNT_W-1:0] cnt_q;

  // >= so a ratio lowered mid-window still closes it
  assign wrap_o = take_i && (cnt_q >= last_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (clr_i)   cnt_q <= '0;
    else if (wrap_o)  cnt_q <= '0;
    else if (take_i)  cnt_q <= cnt_q + 1'b1;
  end

  // R2
  cnt_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take_i && !wrap_o) |=> (cnt_q == $past(cnt_q) + 1'b1));

  // R7
  cnt_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (cnt_q == '0));
endmodule

// File: rtl/osf_accum.sv
module osf_accum #(
  parameter int SMP_W = 12,
  parameter int ACC_W = 20
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             take_i,
  input  logic             wrap_i,
  input  logic             bipolar_i,
  input  logic [SMP_W-1:0] smp_i,
  output logic [ACC_W-1:0] total_o
);
  logic [ACC_W-1:0] acc_q;
  logic [ACC_W-1:0] smp_ext;

  assign smp_ext = bipolar_i ? ACC_W'($signed(smp_i)) : ACC_W'(smp_i);
  assign total_o = acc_q + smp_ext;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      acc_q <= '0;
    else if (clr_i)   acc_q <= '0;
    else if (wrap_i)  acc_q <= '0;
    else if (take_i)  acc_q <= total_o;
  end

  // R5 R6
  acc_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!take_i && !clr_i) |=> $stable(acc_q));

  // R3
  acc_restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wrap_i |=> (acc_q == '0));
endmodule

// File: rtl/osf_top.sv
module osf_top #(
  parameter int SMP_W = 12,
  parameter int ACC_W = 20,
  parameter int MAX_N = 4,
  parameter int SEL_W = 3
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   en_i,
  input  logic                   clr_i,
  input  logic                   bipolar_i,
  input  logic [SEL_W-1:0]       ratio_sel_i,
  input  logic                   smp_vld_i,
  input  logic [SMP_W-1:0]       smp_i,
  input  logic                   src_temp_i,
  output logic [ACC_W-1:0]       sum_o,
  output logic [SMP_W+MAX_N-1:0] ext_o,
  output logic                   done_o
);
  localparam int CNT_W = 2 * MAX_N;
  localparam int SH_W  = $clog2(MAX_N + 1);
  localparam int EXT_W = SMP_W + MAX_N;

  logic             take;
  logic             wrap;
  logic [CNT_W-1:0] last;
  logic [SH_W-1:0]  shift;
  logic [ACC_W-1:0] total;
  logic [ACC_W-1:0] shifted;

  assign take = smp_vld_i && en_i && !src_temp_i && !clr_i;

  osf_ratio_dec #(.SEL_W(SEL_W), .MAX_N(MAX_N), .CNT_W(CNT_W), .SH_W(SH_W)) u_dec (
    .sel_i   (ratio_sel_i),
    .last_o  (last),
    .shift_o (shift)
  );

  osf_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (clr_i),
    .take_i (take),
    .last_i (last),
    .wrap_o (wrap)
  );

  osf_accum #(.SMP_W(SMP_W), .ACC_W(ACC_W)) u_acc (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (clr_i),
    .take_i    (take),
    .wrap_i    (wrap),
    .bipolar_i (bipolar_i),
    .smp_i     (smp_i),
    .total_o   (total)
  );

  assign shifted = bipolar_i ? ACC_W'($signed(total) >>> shift) : (total >> shift);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sum_o  <= '0;
      ext_o  <= '0;
      done_o <= 1'b0;
    end else begin
      done_o <= wrap;
      if (wrap) begin
        sum_o <= total;
        ext_o <= shifted[EXT_W-1:0];
      end
    end
  end

  // R3
  done_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(take));

  // R7
  clr_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (!done_o && $stable(sum_o) && $stable(ext_o)));

  // R5
  temp_nodone_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (smp_vld_i && src_temp_i) |=> !done_o);
endmodule

// File: tb/osf_top_bench.sv
module osf_top_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en = 1'b0, clr = 1'b0, bip = 1'b0, vld = 1'b0, temp = 1'b0;
  logic [2:0]  sel = '0;
  logic [11:0] smp = '0;
  logic [19:0] sum;
  logic [15:0] ext;
  logic        done;

  int checks = 0, failures = 0;
  bit finished = 0;
  logic [35:0] exp_q[$];
  string exp_tag[$];

  always #2.5 clk = ~clk;

  osf_top u_osf_top (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .clr_i(clr), .bipolar_i(bip),
    .ratio_sel_i(sel), .smp_vld_i(vld), .smp_i(smp), .src_temp_i(temp),
    .sum_o(sum), .ext_o(ext), .done_o(done)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // monitor: pop expected result on every done strobe
  always @(negedge clk) begin
    if (rst_n && done) begin
      if (exp_q.size() == 0) begin
        checks++; failures++;
        $display("FAIL R3 actual=unexpected done expected=no done");
      end else begin
        logic [35:0] e;
        string t;
        e = exp_q.pop_front();
        t = exp_tag.pop_front();
        chk({t, " sum"}, 32'(sum), 32'(e[35:16]));
        chk({t, " R4 ext"}, 32'(ext), 32'(e[15:0]));
      end
    end
  end

  task automatic put(input logic [11:0] v, input bit t, input bit e, input bit c);
    vld = 1'b1; smp = v; temp = t; en = e; clr = c;
    @(negedge clk);
    vld = 1'b0; temp = 1'b0; clr = 1'b0; en = 1'b1;
  endtask

  // driver: one full window, expected value pushed before the last sample edge
  task automatic window(input int sel_v, input bit b, input int seed, input bit noise,
                        input int fixed, input string tag);
    int n, len, total;
    n = (sel_v > 4) ? 4 : sel_v;
    len = 1 << (2 * n);
    total = 0;
    sel = 3'(sel_v); bip = b;
    for (int i = 0; i < len; i++) begin
      logic [11:0] v;
      int sv;
      v = (fixed >= 0) ? 12'(fixed) : 12'(seed * 97 + i * 211 + 5);
      sv = b ? int'($signed(v)) : int'(v);
      total += sv;
      if (noise && (i % 3 == 1)) begin
        put(12'hABC, 1'b1, 1'b1, 1'b0); // R5 temp-tagged
        put(12'h7FF, 1'b0, 1'b0, 1'b0); // R6 disabled
      end
      if (i == len - 1) begin
        exp_q.push_back({20'(total), 16'(total >>> n)});
        exp_tag.push_back(tag);
      end
      put(v, 1'b0, 1'b1, 1'b0);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R9
    chk("R9 sum", 32'(sum), 0);
    chk("R9 ext", 32'(ext), 0);
    chk("R9 done", 32'(done), 0);
    rst_n = 1'b1;
    en = 1'b1;
    @(negedge clk);

    window(1, 1'b0, 1, 1'b0, -1, "R1 R2 N1");
    window(2, 1'b0, 2, 1'b1, -1, "R5 R6 N2");
    window(3, 1'b0, 3, 1'b0, -1, "R2 N3");
    window(4, 1'b0, 4, 1'b1, -1, "R2 N4");
    window(0, 1'b0, 5, 1'b0, -1, "R11 N0a");
    window(0, 1'b0, 6, 1'b0, -1, "R11 N0b");
    window(0, 1'b1, 7, 1'b0, 2048, "R11 R8 N0c");
    window(2, 1'b1, 8, 1'b0, -1, "R8 N2");
    window(3, 1'b1, 9, 1'b1, -1, "R8 N3");
    window(7, 1'b0, 10, 1'b0, -1, "R2 clamp");
    window(4, 1'b0, 0, 1'b0, 4095, "R10 uni");
    window(4, 1'b1, 0, 1'b0, 2048, "R10 bip");
    window(1, 1'b0, 0, 1'b0, 0, "R1 zero");

    // R7: clear mid-window, outputs hold, restart from zero
    repeat (2) @(negedge clk);
    sel = 3'd2; bip = 1'b0;
    for (int i = 0; i < 5; i++) put(12'hFFF, 1'b0, 1'b1, 1'b0);
    put(12'h123, 1'b0, 1'b1, 1'b1);
    chk("R7 sum hold", 32'(sum), 0);
    chk("R7 ext hold", 32'(ext), 0);
    chk("R7 done low", 32'(done), 0);
    window(2, 1'b0, 11, 1'b0, -1, "R7 after clr");

    repeat (4) @(negedge clk);
    chk("R3 queue drained", 32'(exp_q.size()), 0);
    chk("R3 done idle", 32'(done), 0);
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++; failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule